// File: doc/BRIEF.md
# External Bus Arbiter for Core and DMA

This block shares one external memory bus between a processor core and a DMA engine. Each side raises a request line. The arbiter picks one of them and asserts a registered, one-hot grant. The granted side keeps the bus until it pulses its transfer-done strobe.

A two-bit policy input chooses how a conflict is resolved, and it can change at run time:

- The DMA side can always win.
- The core can always win.
- The two sides can have equal standing and take turns.
- The core's current two-bit priority level can be compared with the level of the active DMA channel.

A bus-off input stops new grants. It does not cut short a transfer that is already in progress.

Top module: `xbus_arbiter`

## Requirements
- R1: After a synchronous reset, core_gnt, dma_gnt and busy are all 0. The turn-taking pointer favours the core.
- R2: With policy 2'b01, when both sides request while the bus is free and enabled, the next grant goes to the DMA side.
- R3: With policy 2'b11, when both sides request while the bus is free and enabled, the next grant goes to the core.
- R4: With policy 2'b10, a conflict goes to the turn-taking pointer.
  - Any issued grant points the pointer at the other side.
  - The first conflict after reset goes to the core.
- R5: With policy 2'b00, a conflict goes to the side whose two-bit level is strictly greater (core_lvl against dma_lvl). Equal levels fall back to the pointer of R4.
- R6: A lone requester is granted under every policy when the bus is free and enabled.
- R7: A grant appears in the cycle after the cycle in which the bus was free, enabled and requested. No side is granted without a request in the previous cycle.
- R8: A grant stays asserted, whatever the requests do, until xfer_done is seen high while it is held.
  - The grant is low in the next cycle.
  - Arbitration takes place in that free cycle.
- R9: While bus_off is 1, no new grant is issued. A transfer already granted runs on until its xfer_done.
- R10: core_gnt and dma_gnt are never 1 together. busy equals the OR of the two grants.
- R11: xfer_done has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core wants the external bus |
| dma_req | input | 1 | DMA engine wants the external bus |
| core_lvl | input | LVL_W | Current core priority level |
| dma_lvl | input | LVL_W | Priority level of the active DMA channel |
| policy | input | 2 | Conflict policy: 00 compare, 01 DMA first, 10 equal, 11 core first |
| bus_off | input | 1 | Blocks new grants when 1 |
| xfer_done | input | 1 | Current owner finishes its transfer |
| core_gnt | output | 1 | Registered grant to the core |
| dma_gnt | output | 1 | Registered grant to the DMA engine |
| busy | output | 1 | Registered bus-in-use flag |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that xfer_done is meaningful only while a grant is held. The bench drives xfer_done randomly in idle cycles as well, so that the idle case is checked.

The checks assume that the inputs are stable around the rising edge. The bench changes every input only on the falling edge.

Requests, levels and bus_off are drawn at random from a fixed seed. The policy is changed in blocks so that each mode sees many conflicts.

// File: rtl/xarb_pkg.sv
package xarb_pkg;
  typedef enum logic [1:0] {
    POL_COMPARE = 2'b00,
    POL_DMA_HI  = 2'b01,
    POL_EQUAL   = 2'b10,
    POL_CORE_HI = 2'b11
  } policy_e;
endpackage

// File: rtl/xarb_decide.sv
module xarb_decide
  import xarb_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             core_req,
  input  logic             dma_req,
  input  logic [LVL_W-1:0] core_lvl,
  input  logic [LVL_W-1:0] dma_lvl,
  input  logic [1:0]       policy,
  input  logic             turn_core,
  output logic             pick_core,
  output logic             pick_dma
);
  logic core_first;

  always_comb begin
    unique case (policy_e'(policy))
      POL_CORE_HI: core_first = 1'b1;
      POL_DMA_HI:  core_first = 1'b0;
      POL_EQUAL:   core_first = turn_core;
      default: begin
        if (core_lvl > dma_lvl)      core_first = 1'b1;
        else if (core_lvl < dma_lvl) core_first = 1'b0;
        else                         core_first = turn_core;
      end
    endcase
    pick_core = core_req & (~dma_req | core_first);
    pick_dma  = dma_req & (~core_req | ~core_first);
  end
endmodule

// File: rtl/xarb_turn.sv
module xarb_turn (
  input  logic clk,
  input  logic rst,
  input  logic issue_core,
  input  logic issue_dma,
  output logic turn_core
);
  always_ff @(posedge clk) begin
    if (rst)             turn_core <= 1'b1;
    else if (issue_core) turn_core <= 1'b0;
    else if (issue_dma)  turn_core <= 1'b1;
  end

  assert_turn_core_R4: assert property (@(posedge clk) disable iff (rst)
    issue_core |=> !turn_core);
  assert_turn_dma_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_dma && !issue_core) |=> turn_core);
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xarb_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             core_req,
  input  logic             dma_req,
  input  logic [LVL_W-1:0] core_lvl,
  input  logic [LVL_W-1:0] dma_lvl,
  input  logic [1:0]       policy,
  input  logic             bus_off,
  input  logic             xfer_done,
  output logic             core_gnt,
  output logic             dma_gnt,
  output logic             busy
);
  logic turn_core, pick_core, pick_dma;
  logic owned, issue_core, issue_dma;

  xarb_decide #(.LVL_W(LVL_W)) u_decide (
    .core_req  (core_req),
    .dma_req   (dma_req),
    .core_lvl  (core_lvl),
    .dma_lvl   (dma_lvl),
    .policy    (policy),
    .turn_core (turn_core),
    .pick_core (pick_core),
    .pick_dma  (pick_dma)
  );

  assign owned      = core_gnt | dma_gnt;
  assign issue_core = ~owned & ~bus_off & pick_core;
  assign issue_dma  = ~owned & ~bus_off & pick_dma;

  xarb_turn u_turn (
    .clk        (clk),
    .rst        (rst),
    .issue_core (issue_core),
    .issue_dma  (issue_dma),
    .turn_core  (turn_core)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_gnt <= 1'b0;
      dma_gnt  <= 1'b0;
    end else if (owned) begin
      if (xfer_done) begin
        core_gnt <= 1'b0;
        dma_gnt  <= 1'b0;
      end
    end else begin
      core_gnt <= issue_core;
      dma_gnt  <= issue_dma;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       busy <= 1'b0;
    else if (busy) busy <= ~xfer_done;
    else           busy <= issue_core | issue_dma;
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(core_gnt && dma_gnt));
  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy == (core_gnt || dma_gnt));
  assert_hold_core_R8: assert property (@(posedge clk) disable iff (rst)
    (core_gnt && !xfer_done) |=> core_gnt);
  assert_hold_dma_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_gnt && !xfer_done) |=> dma_gnt);
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    ((core_gnt || dma_gnt) && xfer_done) |=> !(core_gnt || dma_gnt));
  assert_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!core_gnt && !dma_gnt && bus_off) |=> !(core_gnt || dma_gnt));
  assert_noreq_core_R7: assert property (@(posedge clk) disable iff (rst)
    (!core_gnt && !dma_gnt && !core_req) |=> !core_gnt);
  assert_noreq_dma_R7: assert property (@(posedge clk) disable iff (rst)
    (!core_gnt && !dma_gnt && !dma_req) |=> !dma_gnt);
  assert_dmahi_R2: assert property (@(posedge clk) disable iff (rst)
    (!core_gnt && !dma_gnt && !bus_off && core_req && dma_req && policy == 2'b01)
    |=> dma_gnt);
  assert_corehi_R3: assert property (@(posedge clk) disable iff (rst)
    (!core_gnt && !dma_gnt && !bus_off && core_req && dma_req && policy == 2'b11)
    |=> core_gnt);
endmodule

// File: tb/sim_xbus_arbiter.sv
`timescale 1ns/1ps
module sim_xbus_arbiter;
  localparam int LVL_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_req = 0, dma_req = 0, bus_off = 0, xfer_done = 0;
  logic [LVL_W-1:0] core_lvl = '0, dma_lvl = '0;
  logic [1:0] policy = 2'b11;
  logic core_gnt, dma_gnt, busy;

  int tests = 0, fails = 0;
  bit ended = 0;
  bit m_core = 0, m_dma = 0, m_turn = 1;

  always #2 clk = ~clk;

  xbus_arbiter #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst(rst), .core_req(core_req), .dma_req(dma_req),
    .core_lvl(core_lvl), .dma_lvl(dma_lvl), .policy(policy),
    .bus_off(bus_off), .xfer_done(xfer_done),
    .core_gnt(core_gnt), .dma_gnt(dma_gnt), .busy(busy)
  );

  // Returns {core_wins, dma_wins} for a free, enabled bus
  function automatic logic [1:0] winner(input logic c, input logic d,
      input logic [LVL_W-1:0] cl, input logic [LVL_W-1:0] dl,
      input logic [1:0] pol, input logic turn);
    logic cf;
    case (pol)
      2'b11: cf = 1'b1;
      2'b01: cf = 1'b0;
      2'b10: cf = turn;
      default: cf = (cl > dl) ? 1'b1 : ((cl < dl) ? 1'b0 : turn);
    endcase
    if (c && d) return cf ? 2'b10 : 2'b01;
    return {c, d};
  endfunction

  function automatic string conflict_tag(input logic [1:0] pol);
    case (pol)
      2'b01: return "R2";
      2'b11: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {core_gnt,dma_gnt,busy} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // One cycle: drive on the falling edge, advance the model, compare after the rising edge
  task automatic cyc(input logic c, input logic d, input logic [LVL_W-1:0] cl,
      input logic [LVL_W-1:0] dl, input logic [1:0] pol, input logic off,
      input logic done, input string tag_in);
    string tag;
    logic [1:0] w;
    @(negedge clk);
    core_req = c; dma_req = d; core_lvl = cl; dma_lvl = dl;
    policy = pol; bus_off = off; xfer_done = done;
    tag = tag_in;
    if (m_core || m_dma) begin
      if (done) begin m_core = 0; m_dma = 0; end
      if (tag == "") tag = "R8";
    end else if (off) begin
      if (tag == "") tag = "R9";
    end else begin
      w = winner(c, d, cl, dl, pol, m_turn);
      if (tag == "") tag = (c && d) ? conflict_tag(pol) : ((c || d) ? "R6" : "R7");
      if (w[1]) begin m_core = 1; m_turn = 0; end
      else if (w[0]) begin m_dma = 1; m_turn = 1; end
    end
    @(posedge clk);
    #1;
    check(tag, {core_gnt, dma_gnt, busy}, {m_core, m_dma, m_core | m_dma});
    tests++;
    if (core_gnt && dma_gnt) begin
      fails++;
      $display("FAIL R10: both grants actual=11 expected one-hot");
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {core_gnt, dma_gnt, busy}, 3'b000);
    @(negedge clk);
    rst = 0;
    m_core = 0; m_dma = 0; m_turn = 1;

    // R4: the first tie after reset goes to the core, the next one to DMA
    cyc(1, 1, 0, 0, 2'b10, 0, 0, "R4");
    cyc(1, 1, 0, 0, 2'b10, 0, 1, "R8");
    cyc(1, 1, 0, 0, 2'b10, 0, 0, "R4");
    cyc(0, 0, 0, 0, 2'b10, 0, 1, "R8");
    // R2 and R3: fixed orders
    cyc(1, 1, 0, 0, 2'b01, 0, 0, "R2");
    cyc(0, 0, 0, 0, 2'b01, 0, 1, "R8");
    cyc(1, 1, 0, 0, 2'b11, 0, 0, "R3");
    cyc(0, 0, 0, 0, 2'b11, 0, 1, "R8");
    // R5: level comparison in both directions
    cyc(1, 1, 2, 1, 2'b00, 0, 0, "R5");
    cyc(0, 0, 0, 0, 2'b00, 0, 1, "R8");
    cyc(1, 1, 1, 3, 2'b00, 0, 0, "R5");
    cyc(0, 0, 0, 0, 2'b00, 0, 1, "R8");
    // R8: the grant holds while the requests change
    cyc(1, 0, 0, 0, 2'b11, 0, 0, "R6");
    for (int i = 0; i < 4; i++) cyc(i[0], 1, 0, 0, 2'b01, 0, 0, "R8");
    cyc(0, 1, 0, 0, 2'b01, 0, 1, "R8");
    cyc(0, 1, 0, 0, 2'b01, 0, 0, "R8");
    // R9: bus_off raised mid-transfer lets it finish, then blocks
    cyc(0, 0, 0, 0, 2'b01, 1, 0, "R9");
    cyc(1, 1, 0, 0, 2'b01, 1, 1, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 2'b01, 1, 0, "R9");
    // R11: done while idle has no effect, the bus is still granted
    cyc(0, 0, 0, 0, 2'b01, 0, 1, "R11");
    cyc(1, 0, 0, 0, 2'b01, 0, 1, "R11");
    cyc(0, 0, 0, 0, 2'b01, 0, 1, "R8");

    // Random traffic: the policy is changed in blocks
    for (int blk = 0; blk < 40; blk++) begin
      logic [1:0] pol;
      pol = 2'($urandom_range(0, 3));
      for (int i = 0; i < 200; i++) begin
        cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            LVL_W'($urandom_range(0, 3)), LVL_W'($urandom_range(0, 3)),
            pol, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) < 4), "");
      end
    end
    finish_run();
  end
endmodule